// File: doc/BRIEF.md
# Link Word Transmit and Receive Queues

This block sits between software and a serial link shifter and buffers single link words in both directions. Software writes words into the back of a three-entry transmit queue. The shifter takes words from the front of that queue. In the other direction the shifter pushes received words into a three-entry receive queue, and software reads them from its front. Because of the queues, the shifter can send or receive the next word immediately after the current one, with no idle cycle in between.

The block reports three status flags. One shows that the transmit queue has room. One shows that the receive queue holds data. The third is a sticky overflow flag. It is set when the shifter delivers a word that the full receive queue cannot take, and that word is discarded. Two interrupt outputs pulse for one cycle when the room flag or the data flag changes from 0 to 1. Each interrupt has its own enable.

Top module: `link_word_queues`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), both queues are empty, `tx_not_full` is 1, and `rx_not_empty`, `rx_overflow`, `shf_tx_valid`, `irq_tnf` and `irq_rne` are 0.
- R2: The transmit queue holds up to 3 words. `tx_not_full` is 1 while it holds fewer than 3 words and 0 when it holds 3. `shf_tx_valid` is 1 whenever it holds at least one word.
- R3: A `sw_tx_wr` while the transmit queue holds 3 words, with no `shf_tx_pop` in the same cycle, is ignored, and the queued words and their order do not change.
- R4: The receive queue holds up to 3 words in arrival order. `rx_not_empty` is 1 whenever it holds at least one word.
- R5: A `shf_rx_push` while the receive queue holds 3 words, with no `sw_rx_rd` in the same cycle, discards the word and sets `rx_overflow` from the next cycle on.
- R6: `rx_overflow` stays 1 until a cycle with `ovf_clr` high clears it. If a new overflow occurs in the same cycle as `ovf_clr`, the flag stays set.
- R7: A push and a pop in the same cycle both take effect at any fill level, including a full queue, so words move back-to-back.
- R8: A pop from an empty queue (`shf_tx_pop` or `sw_rx_rd`) is ignored and leaves the queue empty.
- R9: `irq_tnf` is high for exactly the first cycle in which `tx_not_full` is 1 after having been 0, and only while `irq_tnf_en` is 1. It is never high at any other time.
- R10: `irq_rne` is high for exactly the first cycle in which `rx_not_empty` is 1 after having been 0, and only while `irq_rne_en` is 1. It is never high at any other time.
- R11: `shf_tx_data` presents the oldest transmit word and `sw_rx_data` presents the oldest receive word whenever the respective queue is not empty, without needing a read strobe first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_tx_wr | input | 1 | Software write strobe into the transmit queue |
| sw_tx_data | input | WORD_W | Word written by software |
| shf_tx_pop | input | 1 | Shifter takes the front transmit word |
| shf_tx_valid | output | 1 | Transmit queue holds a word |
| shf_tx_data | output | WORD_W | Front word of the transmit queue |
| shf_rx_push | input | 1 | Shifter delivers a received word |
| shf_rx_data | input | WORD_W | Received word |
| sw_rx_rd | input | 1 | Software read strobe; removes the front receive word |
| sw_rx_data | output | WORD_W | Front word of the receive queue |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| irq_tnf_en | input | 1 | Enable for the transmit room interrupt |
| irq_rne_en | input | 1 | Enable for the receive data interrupt |
| tx_not_full | output | 1 | Transmit queue has room |
| rx_not_empty | output | 1 | Receive queue holds data |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| irq_tnf | output | 1 | One-cycle pulse when the transmit room flag rises |
| irq_rne | output | 1 | One-cycle pulse when the receive data flag rises |

## Verification
The bench targets the full-queue corner cases. These include a software write into a full transmit queue, which would corrupt or reorder the queued words if accepted. They also include a push and a pop arriving together at a full queue: a design that refuses the push there would stall the shifter, or set overflow without cause. The bench clears the overflow flag in the same cycle as a new overflow. If the clear wins, the error is lost. The bench also pops empty queues, which would wrap the pointers if not blocked. It repeats the 0-to-1 transitions of both flags, with the enables on and off, to catch interrupts that are held high, that fire at reset, or that fire on the falling edge.

// File: rtl/lwq_pkg.sv
// Shared constants for the link word queue block.
// Assumes: two interrupt sources, indexed as below.
package lwq_pkg;
    localparam int IRQ_TNF = 0;                    // transmit room interrupt index
    localparam int IRQ_RNE = 1;                    // receive data interrupt index
    localparam int IRQ_N   = 2;                    // number of interrupt sources
    // Value each watched flag takes out of reset (room=1, data=0)
    localparam logic [IRQ_N-1:0] IRQ_PREV_INIT = 2'b01;
endpackage

// File: rtl/lwq_fifo.sv
// First-word-fall-through queue with DEPTH entries.
// A pop on an empty queue is ignored. A push on a full queue is accepted only when
// a pop succeeds in the same cycle. The front word is valid whenever empty is 0.
// Assumes DEPTH >= 1. Storage is not reset; it is only read where it holds valid data.
module lwq_fifo #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] front,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    // Advance a pointer with wrap at the last entry
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Decide which requests take effect this cycle
    always_comb begin
        empty   = (count == '0);
        full    = (count == CAP);
        do_pop  = pop & ~empty;
        do_push = push & (~full | do_pop);
        front   = mem[rd_ptr];
    end

    // Write the accepted word into storage
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Track pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/lwq_rise_irq.sv
// Makes a one-cycle interrupt pulse in the first cycle that a status flag is 1
// after having been 0, gated by an enable.
// Assumes: PREV_INIT equals the flag's value out of reset, so reset makes no pulse.
module lwq_rise_irq #(
    parameter logic PREV_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic en,
    output logic irq
);
    logic prev_q;

    // Remember the flag value of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= PREV_INIT;
        else        prev_q <= flag;
    end

    // Pulse on a 0-to-1 change when enabled
    always_comb irq = en & flag & ~prev_q;
endmodule

// File: rtl/link_word_queues.sv
// Transmit and receive queues for single link words, with status flags and interrupts.
// Software fills the transmit queue and drains the receive queue. The shifter does the reverse.
// A word that reaches a full receive queue is dropped, and a sticky overflow flag is set.
// Assumes: all strobes are synchronous to clk; ovf_clr is a write-one-to-clear strobe.
module link_word_queues #(
    parameter int WORD_W = 24,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_tx_wr,
    input  logic [WORD_W-1:0] sw_tx_data,
    input  logic              shf_tx_pop,
    output logic              shf_tx_valid,
    output logic [WORD_W-1:0] shf_tx_data,
    input  logic              shf_rx_push,
    input  logic [WORD_W-1:0] shf_rx_data,
    input  logic              sw_rx_rd,
    output logic [WORD_W-1:0] sw_rx_data,
    input  logic              ovf_clr,
    input  logic              irq_tnf_en,
    input  logic              irq_rne_en,
    output logic              tx_not_full,
    output logic              rx_not_empty,
    output logic              rx_overflow,
    output logic              irq_tnf,
    output logic              irq_rne
);
    import lwq_pkg::*;

    logic tx_full, tx_empty, rx_full, rx_empty;
    logic rx_drop;
    logic [IRQ_N-1:0] irq_flag, irq_en, irq_vec;

    // Transmit queue: software is the producer, the shifter the consumer
    lwq_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) i_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sw_tx_wr),
        .din   (sw_tx_data),
        .pop   (shf_tx_pop),
        .front (shf_tx_data),
        .full  (tx_full),
        .empty (tx_empty)
    );

    // Receive queue: the shifter is the producer, software the consumer
    lwq_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) i_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (shf_rx_push),
        .din   (shf_rx_data),
        .pop   (sw_rx_rd),
        .front (sw_rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // Derive status flags from queue occupancy
    always_comb begin
        shf_tx_valid = ~tx_empty;
        tx_not_full  = ~tx_full;
        rx_not_empty = ~rx_empty;
        rx_drop      = shf_rx_push & rx_full & ~sw_rx_rd;
    end

    // Sticky overflow; a new drop takes priority over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_overflow <= 1'b0;
        else if (rx_drop) rx_overflow <= 1'b1;
        else if (ovf_clr) rx_overflow <= 1'b0;
    end

    // Gather the flags and enables that drive the interrupt generators
    always_comb begin
        irq_flag[IRQ_TNF] = tx_not_full;
        irq_flag[IRQ_RNE] = rx_not_empty;
        irq_en[IRQ_TNF]   = irq_tnf_en;
        irq_en[IRQ_RNE]   = irq_rne_en;
        irq_tnf           = irq_vec[IRQ_TNF];
        irq_rne           = irq_vec[IRQ_RNE];
    end

    // One rising-edge interrupt generator per status flag
    for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
        lwq_rise_irq #(.PREV_INIT(IRQ_PREV_INIT[g])) i_rise (
            .clk   (clk),
            .rst_n (rst_n),
            .flag  (irq_flag[g]),
            .en    (irq_en[g]),
            .irq   (irq_vec[g])
        );
    end
endmodule

// File: rtl/link_word_queues_checker.sv
// Property checker for link_word_queues. It watches ports and queue full/empty state.
// Assumes: attached with the bind below; reset is synchronous and active low.
module link_word_queues_checker (
    input logic clk,
    input logic rst_n,
    input logic sw_tx_wr,
    input logic shf_tx_pop,
    input logic shf_rx_push,
    input logic sw_rx_rd,
    input logic ovf_clr,
    input logic irq_tnf_en,
    input logic irq_rne_en,
    input logic tx_full,
    input logic tx_empty,
    input logic rx_full,
    input logic tx_not_full,
    input logic rx_not_empty,
    input logic rx_overflow,
    input logic irq_tnf,
    input logic irq_rne
);
    // R1: first cycle out of reset shows the idle state
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tx_not_full && !rx_not_empty && !rx_overflow && !irq_tnf && !irq_rne));

    // R3: an unmatched write into a full transmit queue leaves it full
    a_r3_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && sw_tx_wr && !shf_tx_pop) |=> tx_full);

    // R5: a drop sets the overflow flag
    a_r5_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (shf_rx_push && rx_full && !sw_rx_rd) |=> rx_overflow);

    // R6: overflow holds until cleared
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !ovf_clr) |=> rx_overflow);

    // R7: a push and a pop together at a full transmit queue keep it full
    a_r7_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && sw_tx_wr && shf_tx_pop) |=> tx_full);

    // R8: a pop on an empty transmit queue without a write keeps it empty
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && shf_tx_pop && !sw_tx_wr) |=> tx_empty);

    // R9: the room interrupt is a gated single-cycle pulse
    a_r9_tnf_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tnf |-> (irq_tnf_en && tx_not_full));
    a_r9_tnf_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tnf |=> !irq_tnf);

    // R10: the data interrupt is a gated single-cycle pulse
    a_r10_rne_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rne |-> (irq_rne_en && rx_not_empty));
    a_r10_rne_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rne |=> !irq_rne);
endmodule

bind link_word_queues link_word_queues_checker i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_tx_wr     (sw_tx_wr),
    .shf_tx_pop   (shf_tx_pop),
    .shf_rx_push  (shf_rx_push),
    .sw_rx_rd     (sw_rx_rd),
    .ovf_clr      (ovf_clr),
    .irq_tnf_en   (irq_tnf_en),
    .irq_rne_en   (irq_rne_en),
    .tx_full      (tx_full),
    .tx_empty     (tx_empty),
    .rx_full      (rx_full),
    .tx_not_full  (tx_not_full),
    .rx_not_empty (rx_not_empty),
    .rx_overflow  (rx_overflow),
    .irq_tnf      (irq_tnf),
    .irq_rne      (irq_rne)
);

// File: tb/test_link_word_queues.sv
// Bench for link_word_queues. A behavioural model built on queues is compared on every cycle.
module test_link_word_queues;
    localparam int CLK_PERIOD = 10;
    localparam int W = 24;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_tx_wr = 0, shf_tx_pop = 0, shf_rx_push = 0, sw_rx_rd = 0, ovf_clr = 0;
    logic irq_tnf_en = 0, irq_rne_en = 0;
    logic [W-1:0] sw_tx_data = '0, shf_rx_data = '0;
    logic shf_tx_valid, tx_not_full, rx_not_empty, rx_overflow, irq_tnf, irq_rne;
    logic [W-1:0] shf_tx_data, sw_rx_data;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Reference state
    logic [W-1:0] txq[$];
    logic [W-1:0] rxq[$];
    bit m_ovf = 0;
    bit prev_tnf = 1;
    bit prev_rne = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_word_queues #(.WORD_W(W), .DEPTH(D)) i_link_word_queues (
        .clk(clk), .rst_n(rst_n),
        .sw_tx_wr(sw_tx_wr), .sw_tx_data(sw_tx_data),
        .shf_tx_pop(shf_tx_pop), .shf_tx_valid(shf_tx_valid), .shf_tx_data(shf_tx_data),
        .shf_rx_push(shf_rx_push), .shf_rx_data(shf_rx_data),
        .sw_rx_rd(sw_rx_rd), .sw_rx_data(sw_rx_data),
        .ovf_clr(ovf_clr), .irq_tnf_en(irq_tnf_en), .irq_rne_en(irq_rne_en),
        .tx_not_full(tx_not_full), .rx_not_empty(rx_not_empty), .rx_overflow(rx_overflow),
        .irq_tnf(irq_tnf), .irq_rne(irq_rne)
    );

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model (outputs depend only on state and enables)
    task automatic compare();
        bit tnf = txq.size() < D;
        bit rne = rxq.size() > 0;
        check("R2 tx_not_full", 32'(tx_not_full), 32'(tnf));
        check("R2 shf_tx_valid", 32'(shf_tx_valid), 32'(txq.size() > 0));
        check("R4 rx_not_empty", 32'(rx_not_empty), 32'(rne));
        check("R5 rx_overflow", 32'(rx_overflow), 32'(m_ovf));
        check("R9 irq_tnf", 32'(irq_tnf), 32'(irq_tnf_en && tnf && !prev_tnf));
        check("R10 irq_rne", 32'(irq_rne), 32'(irq_rne_en && rne && !prev_rne));
        if (txq.size() > 0) check("R11 shf_tx_data", 32'(shf_tx_data), 32'(txq[0]));
        if (rxq.size() > 0) check("R11 sw_rx_data", 32'(sw_rx_data), 32'(rxq[0]));
    endtask

    // Advance the model by one clock using the current strobes
    task automatic model_clock();
        bit tpop = shf_tx_pop && txq.size() > 0;
        bit tpush = sw_tx_wr && (txq.size() < D || tpop);
        bit rpop = sw_rx_rd && rxq.size() > 0;
        bit rpush = shf_rx_push && (rxq.size() < D || rpop);
        prev_tnf = txq.size() < D;
        prev_rne = rxq.size() > 0;
        if (tpop) void'(txq.pop_front());
        if (tpush) txq.push_back(sw_tx_data);
        if (rpop) void'(rxq.pop_front());
        if (rpush) rxq.push_back(shf_rx_data);
        if (shf_rx_push && !rpush) m_ovf = 1;
        else if (ovf_clr) m_ovf = 0;
    endtask

    // Caller has set strobes just after a falling edge; compare, clock, then clear strobes
    task automatic step();
        #1 compare();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        sw_tx_wr = 0; shf_tx_pop = 0; shf_rx_push = 0; sw_rx_rd = 0; ovf_clr = 0;
    endtask

    task automatic tx_write(logic [W-1:0] d);
        sw_tx_wr = 1; sw_tx_data = d; step();
    endtask

    task automatic rx_deliver(logic [W-1:0] d);
        shf_rx_push = 1; shf_rx_data = d; step();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle state right after reset
        cur_req = "R1";
        #1;
        check("R1 tx_not_full", 32'(tx_not_full), 1);
        check("R1 rx_not_empty", 32'(rx_not_empty), 0);
        check("R1 rx_overflow", 32'(rx_overflow), 0);
        check("R1 shf_tx_valid", 32'(shf_tx_valid), 0);
        check("R1 irqs", 32'({irq_tnf, irq_rne}), 0);
        step();

        irq_tnf_en = 1; irq_rne_en = 1;
        // R2: fill the transmit queue
        cur_req = "R2";
        tx_write(24'h111111); tx_write(24'h222222); tx_write(24'h333333);
        // R3: write into the full queue is ignored
        cur_req = "R3";
        tx_write(24'hBADBAD); step();
        // R11 and R9: drain in order; room interrupt on first pop
        cur_req = "R9";
        for (int i = 0; i < 3; i++) begin shf_tx_pop = 1; step(); end
        // R8: pop on empty transmit queue
        cur_req = "R8";
        shf_tx_pop = 1; step(); step();

        // R4 and R10: fill receive queue
        cur_req = "R4";
        rx_deliver(24'hA00001); rx_deliver(24'hA00002); rx_deliver(24'hA00003);
        // R5: fourth word dropped
        cur_req = "R5";
        rx_deliver(24'hDEAD00); step();
        // R6: stays set, then clear
        cur_req = "R6";
        step(); ovf_clr = 1; step(); step();
        // R6: new drop in the same cycle as clear keeps the flag
        shf_rx_push = 1; shf_rx_data = 24'hDEAD01; ovf_clr = 1; step(); step();
        ovf_clr = 1; step();
        // R7: push and pop together at a full receive queue
        cur_req = "R7";
        shf_rx_push = 1; shf_rx_data = 24'hB00001; sw_rx_rd = 1; step(); step();
        // R8: drain and over-read receive queue
        cur_req = "R8";
        for (int i = 0; i < 4; i++) begin sw_rx_rd = 1; step(); end
        // R7: full transmit queue with simultaneous write and pop
        cur_req = "R7";
        tx_write(24'h000A01); tx_write(24'h000A02); tx_write(24'h000A03);
        sw_tx_wr = 1; sw_tx_data = 24'h000A04; shf_tx_pop = 1; step(); step();

        // R9 and R10 with enables off: no pulses
        cur_req = "R9";
        irq_tnf_en = 0; irq_rne_en = 0;
        shf_tx_pop = 1; step(); rx_deliver(24'hC00001); sw_rx_rd = 1; step();

        // Mixed random traffic with enables toggling
        cur_req = "R7";
        for (int i = 0; i < 2000; i++) begin
            sw_tx_wr = 1'($urandom_range(0, 1)); sw_tx_data = W'($urandom);
            shf_tx_pop = 1'($urandom_range(0, 1));
            shf_rx_push = 1'($urandom_range(0, 1)); shf_rx_data = W'($urandom);
            sw_rx_rd = 1'($urandom_range(0, 2) == 0);
            ovf_clr = 1'($urandom_range(0, 7) == 0);
            irq_tnf_en = 1'($urandom_range(0, 3) != 0);
            irq_rne_en = 1'($urandom_range(0, 3) != 0);
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule